// File: doc/BRIEF.md
# Packet Pointer and Data Port

This block gives a host indirect access to packet RAM through two registers. The host first writes a 16-bit pointer. The pointer picks where the packet number comes from, sets a byte offset inside the packet, sets the transfer direction and turns on optional auto-increment. After that, the host moves data through a data port that accepts byte or word accesses. The block joins the packet number and the offset into a RAM word address. It drives a synchronous 16-bit RAM port that has byte enables.

The packet number comes from one of two places. It is either the head of the receive queue (an input from queue logic outside this block) or a packet-number register that the host loads. Each packet is laid out by host convention, and the block does not interpret that layout. The layout is:

- a status word at offset 0;
- a length word at offset 2, whose bits 10:0 are significant;
- frame bytes from offset 4;
- a trailing control byte, where bit 5 flags odd length and bit 4 asks for CRC on transmit.

In read mode the block fetches the addressed word ahead of time, so a data read returns at once. Each packet owns a 2048-byte page. The byte address is the packet number times 2048 plus the offset.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset, `ptr_rdata` is 0, `ram_en` and `ram_we` are 0 and `dat_ready` is 1.
- R2: A pointer write stores three flags and the offset, and `ptr_rdata` reads them back one cycle later:
  - bit 15 selects the source (1 = receive-queue head, 0 = packet-number register);
  - bit 14 enables auto-increment;
  - bit 13 selects read mode;
  - bits 10:0 hold the offset.
  Bits 12:11 read back as 0.
- R3: Every RAM access uses `ram_addr = {packet_number, offset[10:1]}`. The packet number is `rxq_head` when bit 15 is set and the packet-number register otherwise. It is sampled in the cycle the access is accepted.
- R4: An accepted write drives `ram_en=1` and `ram_we=1` one cycle later.
  - A word write uses `ram_be=2'b11` and passes `dat_wdata` through unchanged; offset bit 0 is ignored.
  - A byte write uses `ram_be=2'b01` at an even offset and `2'b10` at an odd offset, and copies `dat_wdata[7:0]` onto both lanes.
- R5: With auto-increment enabled, an accepted data access adds 1 to the offset after a byte access and 2 after a word access. The offset wraps within 11 bits. With auto-increment disabled the offset does not change.
- R6: A pointer write with bit 13 set issues a RAM read one cycle later. `dat_ready` is then 0 for two cycles and returns to 1 on the third.
- R7: In read mode, `dat_rdata` returns the prefetched word on a word access. A byte access returns the low byte at an even offset and the high byte at an odd offset, zero-extended. An auto-incremented read starts a new prefetch at the new offset.
- R8: Ignored accesses cause no RAM access and no offset change:
  - data writes while in read mode;
  - data reads while in write mode;
  - data reads while `dat_ready` is 0.
- R9: When a pointer write and a data access fall in the same cycle, the pointer write takes effect and the data access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | 16 | Pointer write value |
| ptr_rdata | output | 16 | Current pointer value |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_wdata | input | PN_W | Packet-number register write value |
| rxq_head | input | PN_W | Packet number at the receive-queue head |
| dat_rd | input | 1 | Data read strobe |
| dat_wr | input | 1 | Data write strobe |
| dat_word | input | 1 | 1 = word access, 0 = byte access |
| dat_wdata | input | 16 | Data write value |
| dat_rdata | output | 16 | Data read value (combinational from the prefetch) |
| dat_ready | output | 1 | Prefetch complete; data reads are accepted |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 2 | RAM byte enables |
| ram_addr | output | PN_W+OFF_W-1 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid the cycle after a read strobe |

## Verification
Results appear at different times after the edge that accepts an access:

- the pointer readback and any RAM strobe, with its address, byte enables and data, are due one cycle after the accepting edge;
- the prefetched data becomes usable three cycles after a pointer write in read mode, with `dat_ready` low in the two cycles between;
- `dat_rdata` is combinational, so it is compared in the same cycle the read is presented.

The bench drives every input on a falling edge and samples at the next falling edge for one-cycle results. It counts further falling edges for the `dat_ready` window, and it samples `dat_rdata` shortly after driving `dat_rd`. The bench model records the address of every prefetch it expects and derives read data from that address, not from the current pointer.

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port #(
  parameter int PN_W  = 4,
  parameter int OFF_W = 11,
  localparam int AW   = PN_W + OFF_W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_we,
  input  logic [15:0]     ptr_wdata,
  output logic [15:0]     ptr_rdata,
  input  logic            pnum_we,
  input  logic [PN_W-1:0] pnum_wdata,
  input  logic [PN_W-1:0] rxq_head,
  input  logic            dat_rd,
  input  logic            dat_wr,
  input  logic            dat_word,
  input  logic [15:0]     dat_wdata,
  output logic [15:0]     dat_rdata,
  output logic            dat_ready,
  output logic            ram_en,
  output logic            ram_we,
  output logic [1:0]      ram_be,
  output logic [AW-1:0]   ram_addr,
  output logic [15:0]     ram_wdata,
  input  logic [15:0]     ram_rdata
);

  logic             src_rx, ainc, rmode, cap_q;
  logic [OFF_W-1:0] off;
  logic [PN_W-1:0]  pnum_q;
  logic [15:0]      pf;

  wire [PN_W-1:0]  cur_pn   = src_rx ? rxq_head : pnum_q;
  wire [PN_W-1:0]  ptr_pn   = ptr_wdata[15] ? rxq_head : pnum_q;
  wire             acc_wr   = dat_wr & ~rmode & ~ptr_we;
  wire             acc_rd   = dat_rd & rmode & dat_ready & ~ptr_we;
  wire [OFF_W-1:0] next_off = off + (dat_word ? OFF_W'(2) : OFF_W'(1));

  assign dat_ready = ~((ram_en & ~ram_we) | cap_q);
  assign ptr_rdata = {src_rx, ainc, rmode, {(13-OFF_W){1'b0}}, off};
  assign dat_rdata = dat_word ? pf : {8'h00, (off[0] ? pf[15:8] : pf[7:0])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_rx    <= 1'b0;
      ainc      <= 1'b0;
      rmode     <= 1'b0;
      off       <= '0;
      pnum_q    <= '0;
      pf        <= '0;
      cap_q     <= 1'b0;
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_be    <= 2'b00;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_en <= 1'b0;
      ram_we <= 1'b0;
      cap_q  <= ram_en & ~ram_we;
      if (cap_q) pf <= ram_rdata;
      if (pnum_we) pnum_q <= pnum_wdata;

      if (ptr_we) begin
        src_rx <= ptr_wdata[15];
        ainc   <= ptr_wdata[14];
        rmode  <= ptr_wdata[13];
        off    <= ptr_wdata[OFF_W-1:0];
        if (ptr_wdata[13]) begin
          ram_en   <= 1'b1;
          ram_be   <= 2'b11;
          ram_addr <= {ptr_pn, ptr_wdata[OFF_W-1:1]};
        end
      end else if (acc_wr) begin
        ram_en    <= 1'b1;
        ram_we    <= 1'b1;
        ram_addr  <= {cur_pn, off[OFF_W-1:1]};
        ram_be    <= dat_word ? 2'b11 : (off[0] ? 2'b10 : 2'b01);
        ram_wdata <= dat_word ? dat_wdata : {dat_wdata[7:0], dat_wdata[7:0]};
        if (ainc) off <= next_off;
      end else if (acc_rd && ainc) begin
        off      <= next_off;
        ram_en   <= 1'b1;
        ram_be   <= 2'b11;
        ram_addr <= {cur_pn, next_off[OFF_W-1:1]};
      end
    end
  end

endmodule

module pkt_ptr_port_chk #(
  parameter int PN_W  = 4,
  parameter int OFF_W = 11,
  localparam int AW   = PN_W + OFF_W - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_we,
  input logic [15:0]   ptr_wdata,
  input logic [15:0]   ptr_rdata,
  input logic          dat_rd,
  input logic          dat_wr,
  input logic          dat_ready,
  input logic          ram_en,
  input logic          ram_we,
  input logic [1:0]    ram_be,
  input logic [AW-1:0] ram_addr
);

  a_r6_prefetch_issued: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we && ptr_wdata[13] |=> ram_en && !ram_we && !dat_ready);

  a_r8_no_write_in_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[13] && !ptr_we |=> !(ram_en && ram_we));

  a_r5_offset_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we && !dat_rd && !dat_wr |=> $stable(ptr_rdata));

  a_r4_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en && ram_we |-> ram_be != 2'b00);

  a_r8_busy_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_ready && ptr_rdata[13] && !ptr_we && !dat_wr |=> $stable(ptr_rdata[OFF_W-1:0]));

  a_r9_pointer_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_rdata[OFF_W-1:0] == $past(ptr_wdata[OFF_W-1:0]));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[12:11] == 2'b00);

endmodule

bind pkt_ptr_port pkt_ptr_port_chk #(.PN_W(PN_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .ptr_rdata(ptr_rdata), .dat_rd(dat_rd), .dat_wr(dat_wr),
  .dat_ready(dat_ready), .ram_en(ram_en), .ram_we(ram_we),
  .ram_be(ram_be), .ram_addr(ram_addr)
);

// File: tb/pkt_ptr_port_tb_top.sv
`timescale 1ns/1ps
module pkt_ptr_port_tb_top;
  localparam int PN_W = 4;
  localparam int OFF_W = 11;
  localparam int AW = PN_W + OFF_W - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ptr_we = 0, pnum_we = 0, dat_rd = 0, dat_wr = 0, dat_word = 0;
  logic [15:0] ptr_wdata = 0, dat_wdata = 0, ram_rdata = 0;
  logic [PN_W-1:0] pnum_wdata = 0, rxq_head = 0;
  logic [15:0] ptr_rdata, dat_rdata, ram_wdata;
  logic dat_ready, ram_en, ram_we;
  logic [1:0] ram_be;
  logic [AW-1:0] ram_addr;

  always #4 clk = ~clk;

  pkt_ptr_port dut_i (.*);

  function automatic logic [15:0] fmem(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503;
    return t[15:0] ^ 16'h5A5A;
  endfunction

  always_ff @(posedge clk) if (ram_en && !ram_we) ram_rdata <= fmem(ram_addr);

  int tests = 0, fails = 0;
  bit done = 0;
  logic m_rx = 0, m_ainc = 0, m_rd = 0;
  logic [OFF_W-1:0] m_off = 0;
  logic [PN_W-1:0] m_pnum = 0;
  logic [AW-1:0] m_pfa = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PN_W-1:0] cur_pn();
    return m_rx ? rxq_head : m_pnum;
  endfunction

  function automatic logic [15:0] exp_ptr();
    return {m_rx, m_ainc, m_rd, 2'b00, m_off};
  endfunction

  task automatic set_pnum(input logic [PN_W-1:0] v);
    pnum_we = 1; pnum_wdata = v;
    @(posedge clk); @(negedge clk);
    pnum_we = 0; m_pnum = v;
  endtask

  task automatic wait_prefetch();
    @(negedge clk);
    chk(dat_ready == 0, "R6 ready low 2nd cycle", 32'(dat_ready), 0);
    @(negedge clk);
    chk(dat_ready == 1, "R6 ready back", 32'(dat_ready), 1);
  endtask

  task automatic ptr_wr(input logic [15:0] v, input bit with_data);
    ptr_we = 1; ptr_wdata = v;
    if (with_data) begin dat_wr = 1; dat_rd = 1; dat_word = 1; dat_wdata = 16'hDEAD; end
    @(posedge clk); @(negedge clk);
    ptr_we = 0; dat_wr = 0; dat_rd = 0;
    m_rx = v[15]; m_ainc = v[14]; m_rd = v[13]; m_off = v[OFF_W-1:0];
    chk(ptr_rdata == exp_ptr(), with_data ? "R9 pointer wins" : "R2 pointer readback",
        32'(ptr_rdata), 32'(exp_ptr()));
    if (m_rd) begin
      m_pfa = {cur_pn(), m_off[OFF_W-1:1]};
      chk(ram_en && !ram_we && ram_addr == m_pfa, "R3 R6 prefetch address",
          32'(ram_addr), 32'(m_pfa));
      wait_prefetch();
    end else
      chk(!ram_en, with_data ? "R9 data dropped" : "R2 no access in write mode",
          32'(ram_en), 0);
  endtask

  task automatic dwrite(input bit w, input logic [15:0] d);
    logic [AW-1:0] ea;
    logic [1:0] eb;
    logic [15:0] ed;
    ea = {cur_pn(), m_off[OFF_W-1:1]};
    eb = w ? 2'b11 : (m_off[0] ? 2'b10 : 2'b01);
    ed = w ? d : {d[7:0], d[7:0]};
    dat_wr = 1; dat_word = w; dat_wdata = d;
    @(posedge clk); @(negedge clk);
    dat_wr = 0;
    if (m_rd) begin
      chk(!ram_en && ptr_rdata == exp_ptr(), "R8 write ignored in read mode",
          32'(ptr_rdata), 32'(exp_ptr()));
    end else begin
      chk(ram_en && ram_we && ram_addr == ea, "R3 write address", 32'(ram_addr), 32'(ea));
      chk(ram_be == eb && ram_wdata == ed, "R4 lanes and data",
          {14'(0), ram_be, ram_wdata}, {14'(0), eb, ed});
      if (m_ainc) m_off = m_off + (w ? OFF_W'(2) : OFF_W'(1));
      chk(ptr_rdata == exp_ptr(), "R5 offset after write", 32'(ptr_rdata), 32'(exp_ptr()));
    end
  endtask

  task automatic dread(input bit w);
    logic [15:0] v, e;
    v = fmem(m_pfa);
    e = w ? v : {8'h00, (m_off[0] ? v[15:8] : v[7:0])};
    dat_rd = 1; dat_word = w;
    #1;
    if (m_rd) chk(dat_rdata == e, "R7 read data", 32'(dat_rdata), 32'(e));
    @(posedge clk); @(negedge clk);
    dat_rd = 0;
    if (m_rd && m_ainc) begin
      m_off = m_off + (w ? OFF_W'(2) : OFF_W'(1));
      m_pfa = {cur_pn(), m_off[OFF_W-1:1]};
      chk(ptr_rdata == exp_ptr(), "R5 offset after read", 32'(ptr_rdata), 32'(exp_ptr()));
      chk(ram_en && !ram_we && ram_addr == m_pfa, "R7 refetch address",
          32'(ram_addr), 32'(m_pfa));
      wait_prefetch();
    end else
      chk(!ram_en && ptr_rdata == exp_ptr(), m_rd ? "R5 no increment" : "R8 read ignored in write mode",
          32'(ptr_rdata), 32'(exp_ptr()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(ptr_rdata == 0 && !ram_en && !ram_we && dat_ready, "R1 reset state",
        {ptr_rdata, 13'(0), ram_en, ram_we, dat_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    chk(ptr_rdata == 0 && dat_ready, "R1 after release", 32'(ptr_rdata), 0);

    set_pnum(4'h5);
    rxq_head = 4'hA;
    ptr_wr(16'h4000 | 16'h7FF, 0);        // write mode, autoinc, offset 0x7FF
    dwrite(0, 16'h00C3);                  // R5 byte wrap to 0
    ptr_wr(16'h4000 | 16'h7FE, 0);
    dwrite(1, 16'h1234);                  // R5 word wrap to 0
    ptr_wr(16'h0000 | 16'h011, 0);
    dwrite(1, 16'hBEEF);                  // R4 word at odd offset, bit 0 ignored
    dwrite(0, 16'h0077);                  // R5 no autoinc keeps offset
    dread(1);                             // R8 read in write mode
    ptr_wr(16'hE000 | 16'h104, 0);        // R3 rx source, read, autoinc
    dread(0); dread(0); dread(1);
    dwrite(1, 16'h5555);                  // R8 write in read mode
    ptr_wr(16'hA000 | 16'h020, 0);        // read, no autoinc
    dread(0); dread(1);
    // R8 read while not ready
    ptr_we = 1; ptr_wdata = 16'hE000 | 16'h030;
    @(posedge clk); @(negedge clk);
    ptr_we = 0; m_rx = 1; m_ainc = 1; m_rd = 1; m_off = 11'h030;
    m_pfa = {rxq_head, m_off[OFF_W-1:1]};
    dat_rd = 1; dat_word = 1;
    @(posedge clk); @(negedge clk);
    dat_rd = 0;
    chk(!ram_en && ptr_rdata == exp_ptr(), "R8 busy read dropped", 32'(ptr_rdata), 32'(exp_ptr()));
    @(negedge clk);
    chk(dat_ready == 1, "R6 ready after busy", 32'(dat_ready), 1);
    ptr_wr(16'h4000 | 16'h200, 1);        // R9 pointer plus data same cycle

    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 2) begin
        if ($urandom % 2 == 1) set_pnum(PN_W'($urandom));
        rxq_head = PN_W'($urandom);
        ptr_wr({3'(($urandom)), 2'b00, 11'($urandom)}, 0);
      end else if (r == 2) begin
        if (m_rd) dwrite(1'($urandom), 16'($urandom)); else dread(1'($urandom));
      end else if (m_rd) dread(1'($urandom));
      else dwrite(1'($urandom), 16'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule